// File: doc/BRIEF.md
# Segment Table Translation Unit

This block turns a two-part logical address, a segment number plus an offset, into a physical address. Each segment owns a 64-bit descriptor in memory. The descriptors sit in a table whose start address and entry count come in on two configuration inputs. For every accepted request, the unit reads the descriptor as two 32-bit words through a simple read port. It then tests the request and returns one of two outcomes: a physical address, or a trap with a 2-bit code that names the first test that failed.

The tests run in a fixed order: segment number against the table length, the descriptor's valid bit, the offset against the segment limit, and finally the access type against the segment's read, write and execute permissions. An out-of-range segment number is rejected without any memory access. A request that passes all four tests yields the segment base plus the offset. A caller issues one request at a time, waits while busy is high, and picks up the result in the single cycle that done is high.

Top module: `segx_unit`

## Requirements
- R1: After reset, busy, done and rd_req are low.
- R2: For an in-range segment s, the unit reads address tbl_base + 8*s and then tbl_base + 8*s + 4. The first word is descriptor bits 31:0 and the second is bits 63:32. Each address and rd_req are held until the cycle in which rd_valid is high.
- R3: When the segment number is greater than or equal to tbl_len, done rises in the cycle after acceptance with trap high and code 0. No descriptor read is issued.
- R4: A descriptor whose valid flag (bit 56) is 0 gives trap code 1.
- R5: An offset greater than or equal to the limit field (bits 55:32) gives trap code 2.
- R6: The access is checked against the permission flags: code 00 read needs bit 57, 01 write needs bit 58, 10 execute needs bit 59, and code 11 is never allowed. A denied access gives trap code 3.
- R7: When several tests fail, only the first in the order range, valid, limit, permission is reported.
- R8: A request that passes every test gives trap low and phys_addr equal to base (bits 31:0) plus the offset, modulo 2^32.
- R9: done is a single-cycle result strobe, asserted one cycle after the second read completes. busy is high from the cycle after acceptance until that cycle, and is low while done is high.
- R10: A request presented while busy is high is ignored. It starts no read and does not change the result of the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base | input | 32 | Start address of the descriptor table |
| tbl_len | input | SEG_W+1 | Number of segments in the table |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_seg | input | SEG_W | Segment number |
| req_off | input | 24 | Offset within the segment |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10 execute, 11 reserved |
| busy | output | 1 | Translation in progress |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | 32 | Descriptor word address |
| rd_valid | input | 1 | Read data valid, completes the current read |
| rd_data | input | 32 | Read data word |
| done | output | 1 | Result strobe |
| trap | output | 1 | Result is a trap |
| trap_code | output | 2 | 0 range, 1 invalid, 2 limit, 3 permission |
| phys_addr | output | 32 | Translated address when trap is low |

## Verification
Every segment number of a 6-bit configuration is swept against table lengths of 0, 40 and 64, so the range boundary is tried from both sides and at both extremes. The bench computes each descriptor from its index, which gives a spread of valid flags, permission patterns and limits. Every access code is paired with offsets of 0, limit-1, limit and well past the limit. These pairings separate the four trap codes from each other and from success, and the cases that fail more than one test show whether the reporting order is right. One segment's base sits just below 2^32 so that the addition wraps. Memory latency varies from zero to two wait cycles, and extra requests are driven while busy to show that they are ignored.

// File: rtl/segx_pkg.sv
package segx_pkg;

  localparam int PA_W  = 32;
  localparam int LIM_W = 24;

  typedef enum logic [1:0] {
    TRAP_RANGE   = 2'd0,
    TRAP_INVALID = 2'd1,
    TRAP_LIMIT   = 2'd2,
    TRAP_PRIV    = 2'd3
  } trap_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  // 64-bit descriptor, MSB first
  typedef struct packed {
    logic [3:0]       spare;
    logic             may_x;
    logic             may_w;
    logic             may_r;
    logic             live;
    logic [LIM_W-1:0] limit;
    logic [PA_W-1:0]  base;
  } seg_desc_t;

  typedef struct packed {
    logic  fault;
    trap_e code;
  } verdict_t;

  function automatic logic acc_allowed(seg_desc_t d, acc_e a);
    case (a)
      ACC_RD:  return d.may_r;
      ACC_WR:  return d.may_w;
      ACC_EX:  return d.may_x;
      default: return 1'b0;
    endcase
  endfunction

  // Tests after the range test, in priority order
  function automatic verdict_t judge(seg_desc_t d, logic [LIM_W-1:0] off, acc_e a);
    verdict_t v;
    v.fault = 1'b1;
    if (!d.live)                 v.code = TRAP_INVALID;
    else if (off >= d.limit)     v.code = TRAP_LIMIT;
    else if (!acc_allowed(d, a)) v.code = TRAP_PRIV;
    else begin
      v.fault = 1'b0;
      v.code  = TRAP_RANGE;
    end
    return v;
  endfunction

  function automatic logic [PA_W-1:0] relocate(seg_desc_t d, logic [LIM_W-1:0] off);
    return d.base + {{(PA_W-LIM_W){1'b0}}, off};
  endfunction

  function automatic logic [PA_W-1:0] entry_addr(logic [PA_W-1:0] tb, logic [PA_W-1:0] seg);
    return tb + (seg << 3);
  endfunction

endpackage

// File: rtl/segx_fetch.sv
module segx_fetch
  import segx_pkg::*;
#(
  parameter int SEG_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEG_W-1:0]  seg,
  input  logic [PA_W-1:0]   tbl_base,
  output logic              rd_req,
  output logic [PA_W-1:0]   rd_addr,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  output seg_desc_t         desc,
  output logic              desc_ready
);

  typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fstate_e;

  fstate_e         st;
  logic [PA_W-1:0] addr_q;
  logic [31:0]     lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= F_IDLE;
      addr_q <= '0;
      lo_q   <= '0;
    end else begin
      case (st)
        F_IDLE: if (start) begin
          st     <= F_LO;
          addr_q <= entry_addr(tbl_base, {{(PA_W-SEG_W){1'b0}}, seg});
        end
        F_LO: if (rd_valid) begin
          st     <= F_HI;
          lo_q   <= rd_data;
          addr_q <= addr_q + 32'd4;
        end
        F_HI: if (rd_valid) st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end

  assign rd_req     = (st != F_IDLE);
  assign rd_addr    = addr_q;
  assign desc_ready = (st == F_HI) && rd_valid;
  assign desc       = seg_desc_t'({rd_data, lo_q});

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  p_hi_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == F_LO && rd_valid) |=> (rd_req && rd_addr == $past(rd_addr) + 32'd4));

endmodule

// File: rtl/segx_judge.sv
module segx_judge
  import segx_pkg::*;
(
  input  seg_desc_t        desc,
  input  logic [LIM_W-1:0] off,
  input  logic [1:0]       acc,
  output verdict_t         verdict,
  output logic [PA_W-1:0]  phys
);

  always_comb begin
    verdict = judge(desc, off, acc_e'(acc));
    phys    = relocate(desc, off);
  end

endmodule

// File: rtl/segx_unit.sv
module segx_unit
  import segx_pkg::*;
#(
  parameter int SEG_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       tbl_base,
  input  logic [SEG_W:0]    tbl_len,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [23:0]       req_off,
  input  logic [1:0]        req_acc,
  output logic              busy,
  output logic              rd_req,
  output logic [31:0]       rd_addr,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  output logic              done,
  output logic              trap,
  output logic [1:0]        trap_code,
  output logic [31:0]       phys_addr
);

  logic             busy_q, done_q, trap_q;
  trap_e            code_q;
  logic [PA_W-1:0]  phys_q;
  logic [LIM_W-1:0] off_q;
  logic [1:0]       acc_q;

  // named internal events
  logic       accept;
  logic       out_of_range;
  logic       fetch_go;
  logic       fetch_ready;
  seg_desc_t  desc_w;
  verdict_t   verdict_w;
  logic [PA_W-1:0] phys_w;

  assign accept       = req_valid && !busy_q;
  assign out_of_range = ({1'b0, req_seg} >= tbl_len);
  assign fetch_go     = accept && !out_of_range;

  segx_fetch #(.SEG_W(SEG_W)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (fetch_go),
    .seg        (req_seg),
    .tbl_base   (tbl_base),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .desc       (desc_w),
    .desc_ready (fetch_ready)
  );

  segx_judge u_judge (
    .desc    (desc_w),
    .off     (off_q),
    .acc     (acc_q),
    .verdict (verdict_w),
    .phys    (phys_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      trap_q <= 1'b0;
      code_q <= TRAP_RANGE;
      phys_q <= '0;
      off_q  <= '0;
      acc_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        off_q <= req_off;
        acc_q <= req_acc;
        if (out_of_range) begin
          done_q <= 1'b1;
          trap_q <= 1'b1;
          code_q <= TRAP_RANGE;
          phys_q <= '0;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (busy_q && fetch_ready) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        trap_q <= verdict_w.fault;
        code_q <= verdict_w.code;
        phys_q <= verdict_w.fault ? '0 : phys_w;
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign trap      = trap_q;
  assign trap_code = code_q;
  assign phys_addr = phys_q;

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_rdreq_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy);

  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && ({1'b0, req_seg} >= tbl_len))
      |=> (done && trap && trap_code == 2'd0 && !rd_req));

  p_ready_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |=> (done && !busy));

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fetch_ready) |=> (busy && !done));

endmodule

// File: tb/segx_unit_test.sv
`timescale 1ns/1ps
module segx_unit_test;

  localparam int SEG_W = 6;
  localparam int NSEG  = 1 << SEG_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [31:0]      tbl_base = 32'h8000_0000;
  logic [SEG_W:0]   tbl_len = '0;
  logic             req_valid = 1'b0;
  logic [SEG_W-1:0] req_seg = '0;
  logic [23:0]      req_off = '0;
  logic [1:0]       req_acc = '0;
  logic             busy, rd_req, done, trap;
  logic [31:0]      rd_addr, phys_addr;
  logic [1:0]       trap_code;
  logic             rd_valid = 1'b0;
  logic [31:0]      rd_data = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  segx_unit #(.SEG_W(SEG_W)) uut (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .tbl_len(tbl_len),
    .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
    .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .trap(trap), .trap_code(trap_code),
    .phys_addr(phys_addr)
  );

  // descriptor contents computed from the segment index
  function automatic logic [31:0] m_base(int s);
    if (s == NSEG-1) return 32'hFFFF_FF00;
    return 32'h0010_0000 * s + 32'h40 + s;
  endfunction
  function automatic logic [23:0] m_lim(int s);
    return 24'(s * 11 + 3);
  endfunction
  function automatic logic m_live(int s);
    return (s % 7) != 3;
  endfunction
  function automatic logic [2:0] m_perm(int s); // {x,w,r}
    return 3'(s & 7);
  endfunction

  // memory model
  int  n_reads = 0;
  int  rd_total = 0;
  int  wait_cnt = 0;
  int  exp_seg = 0;
  int  half = 0;
  bit  addr_bad = 0;

  initial begin
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (rd_req) begin
        if (wait_cnt >= rd_total % 3) begin
          logic [31:0] rel;
          int sd;
          rel = rd_addr - tbl_base;
          sd  = int'(rel >> 3);
          if (sd != exp_seg || rel[2] != half[0] || rel[1:0] != 2'b00) addr_bad = 1;
          if (sd >= NSEG) rd_data = 32'hDEAD_BEEF;
          else if (!rel[2]) rd_data = m_base(sd);
          else rd_data = {4'b0, m_perm(sd), m_live(sd), m_lim(sd)};
          rd_valid = 1'b1;
          wait_cnt = 0;
          n_reads++;
          rd_total++;
          half++;
        end else wait_cnt++;
      end
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one transaction; spoof drives other requests while busy
  task automatic xlate(int s, logic [23:0] off, logic [1:0] acc, bit spoof);
    int  n;
    int  nfault;
    bit  busy_ok;
    bit  exp_trap;
    logic [1:0]  exp_code;
    logic [31:0] exp_pa;
    logic        perm_ok;
    string tag;
    n_reads = 0; half = 0; addr_bad = 0; exp_seg = s; wait_cnt = 0;
    // expected result from the requirements
    perm_ok  = (acc == 2'd3) ? 1'b0 : m_perm(s)[acc];
    nfault   = 0;
    exp_pa   = 32'h0;
    exp_trap = 1'b1;
    if (s >= int'(tbl_len)) begin exp_code = 2'd0; tag = "R3"; end
    else begin
      if (!m_live(s)) nfault++;
      if (off >= m_lim(s)) nfault++;
      if (!perm_ok) nfault++;
      if (!m_live(s)) begin exp_code = 2'd1; tag = "R4"; end
      else if (off >= m_lim(s)) begin exp_code = 2'd2; tag = "R5"; end
      else if (!perm_ok) begin exp_code = 2'd3; tag = "R6"; end
      else begin exp_code = 2'd0; exp_trap = 1'b0; exp_pa = m_base(s) + {8'b0, off}; tag = "R8"; end
      if (nfault > 1) tag = "R7";
    end
    @(negedge clk);
    req_valid = 1'b1; req_seg = SEG_W'(s); req_off = off; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = 1'b1;
    n = 0;
    while (!done && n < 40) begin
      if (!busy) busy_ok = 1'b0;
      if (spoof) begin
        req_valid = 1'b1; req_seg = SEG_W'(s ^ 5); req_off = 24'h0; req_acc = 2'd0;
      end
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    check(tag, {30'b0, done, trap, 30'b0, exp_trap ? trap_code : 2'b00},
               {30'b0, 1'b1, exp_trap, 30'b0, exp_code});
    if (!exp_trap) check("R8", {32'b0, phys_addr}, {32'b0, exp_pa});
    check(spoof ? "R10" : "R2", {32'b0, 31'b0, addr_bad, 32'(n_reads)},
          {32'b0, 32'b0, 32'(exp_seg < int'(tbl_len) ? 2 : 0)});
    check("R9", {63'b0, busy_ok && !busy}, 64'd1);
    @(negedge clk);
    check("R9", {63'b0, done}, 64'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {61'b0, busy, done, rd_req}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {61'b0, busy, done, rd_req}, 64'd0);

    // main sweep: all segments, all access codes, offsets around the limit
    tbl_len = 7'd40;
    for (int s = 0; s < NSEG; s++)
      for (int a = 0; a < 4; a++) begin
        xlate(s, 24'd0, 2'(a), 0);
        xlate(s, m_lim(s) - 24'd1, 2'(a), 0);
        xlate(s, m_lim(s), 2'(a), 0);
        xlate(s, m_lim(s) + 24'd200, 2'(a), 0);
      end

    // table length extremes: empty and full
    tbl_len = 7'd0;
    for (int s = 0; s < NSEG; s++) xlate(s, 24'd1, 2'd0, 0);
    tbl_len = 7'd64;
    tbl_base = 32'h0000_1000;
    for (int s = 0; s < NSEG; s++) begin
      xlate(s, 24'd2, 2'd0, 0);
      xlate(s, m_lim(s) - 24'd1, 2'd0, 0);
    end

    // R10 requests during busy are ignored
    for (int s = 0; s < NSEG; s += 3) xlate(s, 24'd1, 2'd1, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule